// File: doc/BRIEF.md
# Link Packet Ethernet Encapsulator

This block wraps one extended-address link command packet, plus its optional data payload, inside a single Ethernet frame and streams that frame out one byte per cycle toward a MAC transmit port. A packet is offered with its command words, its payload length in doublewords and the destination MAC address chosen by the earlier address-translation step. The source MAC address comes from a locally configured input, which is sampled when the packet is accepted.

When a packet carries data, the block first collects every payload doubleword into its own storage. Only after the whole payload is held does it begin the frame, so the frame never stalls waiting for data. A control-only packet starts its frame in the very next cycle. Short frames are padded with zero bytes up to the Ethernet minimum. Frame check sequence generation is left to the downstream MAC.

The output uses a valid/ready byte stream with an end-of-frame flag. The block takes no new packet until the final byte of the current frame has been accepted.

Top module: `link_frame_encap`

## Requirements
- R1: After reset, `cmd_ready` is 1 and both `tx_valid` and `dat_ready` are 0.
- R2: Each accepted command packet produces exactly one frame. `cmd_ready` stays 0 from the acceptance cycle until the last frame byte is taken, and it is 1 again in the cycle after that.
- R3: Frame bytes 0 to 5 carry the destination MAC and bytes 6 to 11 carry the source MAC, each sent most significant byte first. Both addresses are captured at acceptance. Bytes 12 and 13 are the type value 0x88 then 0xB5.
- R4: The command words follow from byte 14 onward. Word k is `cmd_words[32k+31:32k]`, with word 0 sent first. The data doublewords come next, in the order they were accepted. Every 32-bit word is sent most significant byte first.
- R5: When the payload count is not zero, `dat_ready` is 1 and `tx_valid` is 0 until the final payload word is accepted. `tx_valid` rises in the next cycle.
- R6: When the payload count is zero, `tx_valid` is 1 in the cycle after acceptance and `dat_ready` never rises.
- R7: A frame whose natural length, 14 + 4·(CMD_DW + n), is below 60 bytes is filled with zero bytes to exactly 60. A longer frame keeps its natural length, which is 62 bytes for eight data words. `tx_last` is 1 on the final byte only.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_byte` and `tx_last` hold their values.
- R9: A payload count above MAX_DW (8) is treated as MAX_DW.
- R10: `dat_valid` has no effect outside payload collection. In that state `dat_ready` is 0 and no word is consumed.
- R11: Changes to `local_mac` or `cmd_dst_mac` after acceptance do not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Configured source MAC address |
| cmd_valid | input | 1 | Command packet offered |
| cmd_ready | output | 1 | Block can accept a command packet |
| cmd_words | input | CMD_DW·32 | Command words, word 0 in the low bits |
| cmd_dst_mac | input | 48 | Destination MAC from translation |
| cmd_ndw | input | NDW_IN_W | Payload length in doublewords |
| dat_valid | input | 1 | Payload doubleword offered |
| dat_ready | output | 1 | Block is collecting payload |
| dat_word | input | 32 | Payload doubleword |
| tx_valid | output | 1 | Frame byte available |
| tx_ready | input | 1 | Sink takes the byte |
| tx_byte | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
A corrupted byte index or a stale stored word shows up as a wrong byte value at the exact frame position where it occurs, within the first frame that reaches that position. A wrong frame-length calculation moves `tx_last` away from byte 59 or 61, and sweeping every payload count from 0 to 8 exposes it at each length. A sequencer state that goes wrong shows within one cycle, either as `tx_valid` overlapping `dat_ready` or as `cmd_ready` failing to return after the last byte.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_SEND    = 2'd2
   } lfe_state_e;

   localparam int        MAC_BYTES  = 6;
   localparam int        HDR_BYTES  = 2 * MAC_BYTES + 2;
   localparam logic [15:0] FRAME_TYPE = 16'h88B5;
endpackage

// File: rtl/lfe_word_store.sv
module lfe_word_store #(
   parameter int CMD_DW   = 4,
   parameter int MAX_DW   = 8,
   parameter int NDW_W    = 4,
   parameter int NDW_IN_W = 4,
   parameter int WORDS_W  = (CMD_DW + MAX_DW) * 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_cmd,
   input  logic [CMD_DW*32-1:0]   cmd_words,
   input  logic [NDW_IN_W-1:0]    cmd_ndw,
   input  logic                   wr_dat,
   input  logic [31:0]            dat_word,
   output logic [WORDS_W-1:0]     words,
   output logic [NDW_W-1:0]       ndw_q,
   output logic                   ndw_nz,
   output logic                   dat_last
);
   logic [NDW_W-1:0] ndw_clamp;
   logic [NDW_W-1:0] dat_cnt;

   // payload counts above the storage depth are limited to it
   always_comb begin
      if (cmd_ndw > NDW_IN_W'(MAX_DW)) ndw_clamp = NDW_W'(MAX_DW);
      else                             ndw_clamp = NDW_W'(cmd_ndw);
   end

   assign ndw_nz   = |cmd_ndw;
   assign dat_last = (dat_cnt == ndw_q - NDW_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ndw_q   <= '0;
         dat_cnt <= '0;
      end else if (load_cmd) begin
         ndw_q   <= ndw_clamp;
         dat_cnt <= '0;
      end else if (wr_dat) begin
         dat_cnt <= dat_cnt + NDW_W'(1);
      end
   end

   for (genvar g = 0; g < CMD_DW; g++) begin : g_cmd
      always_ff @(posedge clk) begin
         if (!rst_n)        words[32*g +: 32] <= '0;
         else if (load_cmd) words[32*g +: 32] <= cmd_words[32*g +: 32];
      end
   end

   for (genvar g = 0; g < MAX_DW; g++) begin : g_dat
      always_ff @(posedge clk) begin
         if (!rst_n)
            words[32*(CMD_DW+g) +: 32] <= '0;
         else if (wr_dat && dat_cnt == NDW_W'(g))
            words[32*(CMD_DW+g) +: 32] <= dat_word;
      end
   end
endmodule

// File: rtl/lfe_byte_mux.sv
module lfe_byte_mux
   import lfe_pkg::*;
#(
   parameter int CMD_DW  = 4,
   parameter int MAX_DW  = 8,
   parameter int MIN_LEN = 60,
   parameter int IDX_W   = 6,
   parameter int NDW_W   = 4,
   parameter int WORDS_W = (CMD_DW + MAX_DW) * 32
) (
   input  logic [IDX_W-1:0]   idx,
   input  logic [47:0]        dst_mac,
   input  logic [47:0]        src_mac,
   input  logic [WORDS_W-1:0] words,
   input  logic [NDW_W-1:0]   ndw,
   output logic [7:0]         byte_o,
   output logic [IDX_W-1:0]   last_idx
);
   logic [15:0] len_raw;

   assign len_raw = 16'(HDR_BYTES + 4 * (CMD_DW + int'(ndw)));

   always_comb begin
      int ii;
      int off;
      int pay;
      ii     = int'(idx);
      pay    = 4 * (CMD_DW + int'(ndw));
      off    = ii - HDR_BYTES;
      byte_o = '0;
      if (ii < MAC_BYTES)
         byte_o = dst_mac[8*(MAC_BYTES-1-ii) +: 8];
      else if (ii < 2*MAC_BYTES)
         byte_o = src_mac[8*(2*MAC_BYTES-1-ii) +: 8];
      else if (ii == 2*MAC_BYTES)
         byte_o = FRAME_TYPE[15:8];
      else if (ii == 2*MAC_BYTES + 1)
         byte_o = FRAME_TYPE[7:0];
      else if (off < pay)
         byte_o = words[32*(off >> 2) + 8*(3 - (off & 3)) +: 8];
   end

   if (MIN_LEN > 0) begin : g_pad
      always_comb begin
         if (len_raw < 16'(MIN_LEN)) last_idx = IDX_W'(MIN_LEN - 1);
         else                        last_idx = IDX_W'(len_raw - 16'd1);
      end
   end else begin : g_nopad
      assign last_idx = IDX_W'(len_raw - 16'd1);
   end
endmodule

// File: rtl/lfe_seq_ctl.sv
module lfe_seq_ctl
   import lfe_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             ndw_nz,
   input  logic             dat_valid,
   input  logic             dat_last,
   input  logic             tx_ready,
   input  logic [IDX_W-1:0] last_idx,
   output logic             cmd_ready,
   output logic             dat_ready,
   output logic             tx_valid,
   output logic             tx_last,
   output logic             load_cmd,
   output logic             wr_dat,
   output logic [IDX_W-1:0] idx
);
   lfe_state_e state;

   assign cmd_ready = (state == ST_IDLE);
   assign dat_ready = (state == ST_COLLECT);
   assign tx_valid  = (state == ST_SEND);
   assign tx_last   = tx_valid && (idx == last_idx);
   assign load_cmd  = cmd_valid && cmd_ready;
   assign wr_dat    = dat_valid && dat_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               idx <= '0;
               if (cmd_valid) state <= ndw_nz ? ST_COLLECT : ST_SEND;
            end
            ST_COLLECT: begin
               if (dat_valid && dat_last) state <= ST_SEND;
            end
            ST_SEND: begin
               if (tx_ready) begin
                  if (idx == last_idx) begin
                     state <= ST_IDLE;
                     idx   <= '0;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/link_frame_encap.sv
module link_frame_encap
   import lfe_pkg::*;
#(
   parameter int CMD_DW   = 4,
   parameter int MAX_DW   = 8,
   parameter int MIN_LEN  = 60,
   parameter int NDW_IN_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [47:0]           local_mac,
   input  logic                  cmd_valid,
   output logic                  cmd_ready,
   input  logic [CMD_DW*32-1:0]  cmd_words,
   input  logic [47:0]           cmd_dst_mac,
   input  logic [NDW_IN_W-1:0]   cmd_ndw,
   input  logic                  dat_valid,
   output logic                  dat_ready,
   input  logic [31:0]           dat_word,
   output logic                  tx_valid,
   input  logic                  tx_ready,
   output logic [7:0]            tx_byte,
   output logic                  tx_last
);
   localparam int TOT_DW  = CMD_DW + MAX_DW;
   localparam int WORDS_W = TOT_DW * 32;
   localparam int NAT_MAX = HDR_BYTES + 4 * TOT_DW;
   localparam int MAX_LEN = (MIN_LEN > NAT_MAX) ? MIN_LEN : NAT_MAX;
   localparam int IDX_W   = $clog2(MAX_LEN);
   localparam int NDW_W   = $clog2(MAX_DW + 1);

   if (CMD_DW < 1) begin : g_chk_cmd
      $error("CMD_DW must be at least 1");
   end
   if (MAX_DW < 1) begin : g_chk_dat
      $error("MAX_DW must be at least 1");
   end
   if (NDW_IN_W < NDW_W) begin : g_chk_ndw
      $error("NDW_IN_W too narrow for MAX_DW");
   end

   logic               load_cmd;
   logic               wr_dat;
   logic               ndw_nz;
   logic               dat_last;
   logic [NDW_W-1:0]   ndw_q;
   logic [WORDS_W-1:0] words;
   logic [IDX_W-1:0]   idx;
   logic [IDX_W-1:0]   last_idx;
   logic [47:0]        dst_q;
   logic [47:0]        src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_q <= '0;
         src_q <= '0;
      end else if (load_cmd) begin
         dst_q <= cmd_dst_mac;
         src_q <= local_mac;
      end
   end

   lfe_word_store #(
      .CMD_DW   (CMD_DW),
      .MAX_DW   (MAX_DW),
      .NDW_W    (NDW_W),
      .NDW_IN_W (NDW_IN_W),
      .WORDS_W  (WORDS_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_cmd  (load_cmd),
      .cmd_words (cmd_words),
      .cmd_ndw   (cmd_ndw),
      .wr_dat    (wr_dat),
      .dat_word  (dat_word),
      .words     (words),
      .ndw_q     (ndw_q),
      .ndw_nz    (ndw_nz),
      .dat_last  (dat_last)
   );

   lfe_byte_mux #(
      .CMD_DW  (CMD_DW),
      .MAX_DW  (MAX_DW),
      .MIN_LEN (MIN_LEN),
      .IDX_W   (IDX_W),
      .NDW_W   (NDW_W),
      .WORDS_W (WORDS_W)
   ) u_mux (
      .idx      (idx),
      .dst_mac  (dst_q),
      .src_mac  (src_q),
      .words    (words),
      .ndw      (ndw_q),
      .byte_o   (tx_byte),
      .last_idx (last_idx)
   );

   lfe_seq_ctl #(
      .IDX_W (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .ndw_nz    (ndw_nz),
      .dat_valid (dat_valid),
      .dat_last  (dat_last),
      .tx_ready  (tx_ready),
      .last_idx  (last_idx),
      .cmd_ready (cmd_ready),
      .dat_ready (dat_ready),
      .tx_valid  (tx_valid),
      .tx_last   (tx_last),
      .load_cmd  (load_cmd),
      .wr_dat    (wr_dat),
      .idx       (idx)
   );
endmodule

// File: rtl/lfe_frame_chk.sv
module lfe_frame_chk #(
   parameter int MIN_LEN  = 60,
   parameter int NDW_IN_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_valid,
   input logic                cmd_ready,
   input logic [NDW_IN_W-1:0] cmd_ndw,
   input logic                dat_ready,
   input logic                tx_valid,
   input logic                tx_ready,
   input logic [7:0]          tx_byte,
   input logic                tx_last
);
   logic [15:0] n_sent;

   always_ff @(posedge clk) begin
      if (!rst_n)                               n_sent <= '0;
      else if (tx_valid && tx_ready && tx_last) n_sent <= '0;
      else if (tx_valid && tx_ready)            n_sent <= n_sent + 16'd1;
   end

   p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !cmd_ready);

   p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> (cmd_ready && !tx_valid));

   p_collect_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_ndw != '0) |=> (dat_ready && !tx_valid));

   p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dat_ready |-> !tx_valid);

   p_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_ndw == '0) |=> (tx_valid && !dat_ready));

   p_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |-> (n_sent + 16'd1 >= 16'(MIN_LEN)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)));

   p_idle_dat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !dat_ready);
endmodule

bind link_frame_encap lfe_frame_chk #(
   .MIN_LEN  (MIN_LEN),
   .NDW_IN_W (NDW_IN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_ndw   (cmd_ndw),
   .dat_ready (dat_ready),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .tx_byte   (tx_byte),
   .tx_last   (tx_last)
);

// File: tb/sim_link_frame_encap.sv
module sim_link_frame_encap;
   localparam int CLK_NS   = 10;
   localparam int CMD_DW   = 4;
   localparam int MAX_DW   = 8;
   localparam int MIN_LEN  = 60;
   localparam int NDW_IN_W = 4;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [47:0]          local_mac = '0;
   logic                 cmd_valid = 1'b0;
   logic                 cmd_ready;
   logic [CMD_DW*32-1:0] cmd_words = '0;
   logic [47:0]          cmd_dst_mac = '0;
   logic [NDW_IN_W-1:0]  cmd_ndw = '0;
   logic                 dat_valid = 1'b0;
   logic                 dat_ready;
   logic [31:0]          dat_word = '0;
   logic                 tx_valid;
   logic                 tx_ready = 1'b0;
   logic [7:0]           tx_byte;
   logic                 tx_last;

   int total = 0;
   int bad   = 0;

   logic [31:0] cw [CMD_DW];
   logic [31:0] dw [MAX_DW];

   link_frame_encap #(
      .CMD_DW   (CMD_DW),
      .MAX_DW   (MAX_DW),
      .MIN_LEN  (MIN_LEN),
      .NDW_IN_W (NDW_IN_W)
   ) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .local_mac   (local_mac),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_words   (cmd_words),
      .cmd_dst_mac (cmd_dst_mac),
      .cmd_ndw     (cmd_ndw),
      .dat_valid   (dat_valid),
      .dat_ready   (dat_ready),
      .dat_word    (dat_word),
      .tx_valid    (tx_valid),
      .tx_ready    (tx_ready),
      .tx_byte     (tx_byte),
      .tx_last     (tx_last)
   );

   initial forever #(CLK_NS/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   function automatic logic [7:0] exp_byte(int i, int n, logic [47:0] d, logic [47:0] s);
      int off;
      logic [31:0] w;
      off = i - 14;
      if (i < 6)  return d[8*(5-i) +: 8];
      if (i < 12) return s[8*(11-i) +: 8];
      if (i == 12) return 8'h88;
      if (i == 13) return 8'hB5;
      if (off < 4*(CMD_DW+n)) begin
         if ((off/4) < CMD_DW) w = cw[off/4];
         else                  w = dw[off/4 - CMD_DW];
         return w[8*(3-(off%4)) +: 8];
      end
      return 8'h00;
   endfunction

   function automatic string region(int i, int n);
      if (i < 12) return "R3 mac";
      if (i < 14) return "R3 type";
      if (i < 14 + 4*CMD_DW) return "R4 cmd";
      if (i < 14 + 4*(CMD_DW+n)) return "R4 data";
      return "R7 pad";
   endfunction

   task automatic run_frame(input int nraw, input int seed, input bit bp);
      int n;
      int exp_len;
      int k;
      int cyc;
      bit done;
      bit held_pend;
      logic [7:0] held_b;
      logic [47:0] dmac;
      logic [47:0] smac;
      n       = (nraw > MAX_DW) ? MAX_DW : nraw;
      exp_len = 14 + 4*(CMD_DW+n);
      if (exp_len < MIN_LEN) exp_len = MIN_LEN;
      for (int j = 0; j < CMD_DW; j++) cw[j] = 32'(seed*32'h01000193 + j*32'h9E3779B9);
      for (int j = 0; j < MAX_DW; j++) dw[j] = 32'(seed*32'h2545F491 + j*32'h6C8E9CF5 + 32'h11);
      dmac = {16'h0200, 32'(seed*32'h000001F3 + 5)};
      smac = {16'h0A00, 32'(seed*32'h00010001 + 7)};

      @(negedge clk);
      local_mac   = smac;
      cmd_dst_mac = dmac;
      cmd_ndw     = NDW_IN_W'(nraw);
      for (int j = 0; j < CMD_DW; j++) cmd_words[32*j +: 32] = cw[j];
      cmd_valid   = 1'b1;
      check(cmd_ready == 1'b1, "R2 ready before packet", longint'(cmd_ready), 1);
      @(posedge clk);
      @(negedge clk);
      cmd_valid   = 1'b0;
      local_mac   = ~smac;   // R11: later changes must not reach the frame
      cmd_dst_mac = ~dmac;
      cmd_words   = '0;

      if (n == 0) begin
         check(tx_valid == 1'b1 && dat_ready == 1'b0, "R6 direct start",
               longint'({tx_valid, dat_ready}), 2);
      end else begin
         check(tx_valid == 1'b0 && dat_ready == 1'b1, "R5 collect entered",
               longint'({tx_valid, dat_ready}), 1);
         k = 0;
         cyc = 0;
         while (k < n) begin
            bit take;
            if (bp && (cyc % 2 == 1)) begin
               dat_valid = 1'b0;
            end else begin
               dat_valid = 1'b1;
               dat_word  = dw[k];
            end
            if (tx_valid) check(1'b0, "R5 frame before payload", 1, 0);
            take = dat_valid && dat_ready;
            @(posedge clk);
            if (take) k++;
            cyc++;
            @(negedge clk);
         end
         dat_valid = 1'b0;
         check(tx_valid == 1'b1, (nraw > MAX_DW) ? "R9 clamped start" : "R5 start after payload",
               longint'(tx_valid), 1);
      end

      k = 0;
      cyc = 0;
      done = 1'b0;
      held_pend = 1'b0;
      held_b = '0;
      while (!done) begin
         tx_ready = bp ? (cyc % 3 != 2) : 1'b1;
         dat_valid = bp;
         if (bp) check(dat_ready == 1'b0, "R10 data ignored while sending", longint'(dat_ready), 0);
         if (!tx_valid) begin
            check(1'b0, "R2 frame dropped", 0, 1);
            break;
         end
         if (held_pend) check(tx_byte == held_b, "R8 byte held", longint'(tx_byte), longint'(held_b));
         if (tx_ready) begin
            logic [7:0] eb;
            eb = exp_byte(k, n, dmac, smac);
            check(tx_byte == eb, region(k, n), longint'(tx_byte), longint'(eb));
            check(tx_last == (k == exp_len-1), "R7 last flag", longint'(tx_last),
                  longint'(k == exp_len-1));
            if (tx_last) done = 1'b1;
            else k++;
            held_pend = 1'b0;
         end else begin
            held_pend = 1'b1;
            held_b = tx_byte;
         end
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (k > exp_len + 4) begin
            check(1'b0, "R7 frame overrun", longint'(k), longint'(exp_len));
            break;
         end
      end
      tx_ready  = 1'b0;
      dat_valid = 1'b0;
      check(k + 1 == exp_len, "R7 frame length", longint'(k + 1), longint'(exp_len));
      check(cmd_ready == 1'b1 && tx_valid == 1'b0, "R2 ready after frame",
            longint'({cmd_ready, tx_valid}), 2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_ready == 1'b1, "R1 cmd_ready", longint'(cmd_ready), 1);
      check(tx_valid == 1'b0, "R1 tx_valid", longint'(tx_valid), 0);
      check(dat_ready == 1'b0, "R1 dat_ready", longint'(dat_ready), 0);

      dat_valid = 1'b1;
      dat_word  = 32'hDEADBEEF;
      check(dat_ready == 1'b0, "R10 data ignored while idle", longint'(dat_ready), 0);
      @(posedge clk);
      @(negedge clk);
      dat_valid = 1'b0;
      check(tx_valid == 1'b0 && cmd_ready == 1'b1, "R10 idle unchanged",
            longint'({tx_valid, cmd_ready}), 1);

      for (int n = 0; n <= 9; n++) run_frame(n, n + 1, 1'b0);
      run_frame(15, 21, 1'b0);
      run_frame(3, 31, 1'b1);
      run_frame(8, 41, 1'b1);
      run_frame(0, 51, 1'b1);
      run_frame(12, 61, 1'b1);

      summary();
      $finish;
   end
endmodule